// File: doc/BRIEF.md
# Clustered Neuron Processing Element with Sum and Max Modes

This block computes the outputs of a cluster of neurons that belong to one layer of a flattened neural network. A single signed multiply-accumulate path handles every neuron. In sum mode the path adds up weight-times-input products, which covers convolution and fully-connected neurons. In max mode the weight is replaced by one and the path keeps the largest input seen, which covers max pooling. Operands arrive one pair per cycle over a valid/ready stream. Each beat carries a flag that closes the current neuron and a flag that closes the whole cluster.

Each finished neuron result is written to a local buffer at the next free slot. When the cluster closes, the element becomes a packet source. It emits one packet for each processing element of the next layer, taking the destination numbers in ascending order. Each packet starts with a header flit, followed by one payload flit per stored result. No operand is accepted while packets are leaving.

Top module: `neuron_pe`

## Requirements
- R1: After reset `busy` and `outValid` are low and `inReady` is high.
- R2: With `modeMax` low, a neuron's result is the sum of signed `inWeight` × signed `inData` over all beats accepted from the neuron's first beat up to and including the beat that closes it.
- R3: Sum mode accumulates at `ACC_W` bits without wrapping. The stored result is clamped to the signed 16-bit range: above 32767 gives 32767, below -32768 gives -32768.
- R4: With `modeMax` high, `inWeight` has no effect and the result is the largest signed `inData` of the neuron. An all-negative neuron yields its largest negative value.
- R5: Payload flits carry the results in the order their neurons closed. Each result is in bits [15:0] and bits [23:16] are zero.
- R6: One packet goes to each destination from `firstPe` up to `firstPe+peCount-1`, in ascending order, one packet after another. The header flit is {dest in [23:16], `srcPe` in [15:8], result count in [7:0]}. With `peCount` zero, nothing is sent and the cluster is discarded.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outFlit` does not change.
- R8: `busy` rises after the first accepted operand of a cluster and falls when the last flit of the last packet is accepted. `inReady` is low for as long as packets are being sent.
- R9: When the buffer holds `SLOTS` results, the cluster closes by itself even without the cluster-end flag.
- R10: A beat that carries the cluster-end flag also closes its neuron, whether or not the neuron-end flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeMax | input | 1 | 1 selects running max, 0 selects weighted sum; hold within a neuron |
| srcPe | input | 8 | Own element number, placed in headers |
| firstPe | input | 8 | First destination element number |
| peCount | input | 8 | Number of next-layer destinations |
| inValid | input | 1 | Operand beat valid |
| inReady | output | 1 | Operand beat accepted when high with inValid |
| inWeight | input | 16 | Signed weight |
| inData | input | 16 | Signed input value |
| inLastNeuron | input | 1 | Beat closes the current neuron |
| inLastGroup | input | 1 | Beat closes the neuron and the cluster |
| outValid | output | 1 | Output flit valid |
| outReady | input | 1 | Downstream accepts the flit |
| outFlit | output | 24 | Header or payload flit |
| busy | output | 1 | Cluster in progress or packets pending |

## Verification
The bench builds the element with `SLOTS` set to 4 and keeps the other parameters at their defaults. The small buffer lets a cluster fill up and close by itself after four neurons. The 40-bit accumulator and 8-bit identifiers stay at full width, so products near the 16-bit limits can overflow 32 bits and exercise clamping in both directions. A cancelling sequence checks that intermediate sums wider than 16 bits still come back exact.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_SEND    = 1'b1
  } pe_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       take;       // operand beat consumed
    logic       close;      // beat ends the current neuron
    logic       clearSlots; // empty the result buffer
    logic       hdrSel;     // present header instead of payload
    logic [7:0] dest;       // destination number for the header
    logic [7:0] rdIdx;      // result slot presented as payload
  } pe_strobe_t;

endpackage

// File: rtl/pe_datapath.sv
module pe_datapath
  import pe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int SLOTS  = 64,
  parameter int ID_W   = 8,
  localparam int SLOT_W = $clog2(SLOTS + 1),
  localparam int ADDR_W = $clog2(SLOTS),
  localparam int FLIT_W = 3 * ID_W,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pe_strobe_t        st,
  input  logic              modeMax,
  input  logic [DATA_W-1:0] inWeight,
  input  logic [DATA_W-1:0] inData,
  input  logic [ID_W-1:0]   srcPe,
  output logic [SLOT_W-1:0] slotCount,
  output logic [FLIT_W-1:0] outFlit
);

  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  acc;
  logic                     fresh;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt, dataExt, sumNext, maxNext, newVal;
  logic [DATA_W-1:0]        clamped;
  logic [DATA_W-1:0]        resBuf [SLOTS];

  always_comb begin
    prod    = $signed(inWeight) * $signed(inData);
    prodExt = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    dataExt = {{(ACC_W-DATA_W){inData[DATA_W-1]}}, inData};
    sumNext = (fresh ? '0 : acc) + prodExt;
    // unit weight: product equals the input itself
    maxNext = (fresh || (dataExt > acc)) ? dataExt : acc;
    newVal  = modeMax ? maxNext : sumNext;
    if (newVal > SAT_HI)      clamped = SAT_HI[DATA_W-1:0];
    else if (newVal < SAT_LO) clamped = SAT_LO[DATA_W-1:0];
    else                      clamped = newVal[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      fresh <= 1'b1;
    end else if (st.take) begin
      if (st.close) begin
        acc   <= '0;
        fresh <= 1'b1;
      end else begin
        acc   <= newVal;
        fresh <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              slotCount <= '0;
    else if (st.clearSlots) slotCount <= '0;
    else if (st.take && st.close) slotCount <= slotCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st.take && st.close) resBuf[slotCount[ADDR_W-1:0]] <= clamped;
  end

  always_comb begin
    if (st.hdrSel)
      outFlit = {st.dest[ID_W-1:0], srcPe, ID_W'(slotCount)};
    else
      outFlit = {{(FLIT_W-DATA_W){1'b0}}, resBuf[st.rdIdx[ADDR_W-1:0]]};
  end

endmodule

// File: rtl/pe_control.sv
module pe_control
  import pe_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int ID_W  = 8,
  localparam int SLOT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLastNeuron,
  input  logic              inLastGroup,
  input  logic [SLOT_W-1:0] slotCount,
  input  logic [ID_W-1:0]   firstPe,
  input  logic [ID_W-1:0]   peCount,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output logic              busy,
  output pe_strobe_t        st
);

  pe_state_t       state;
  logic            groupOpen;
  logic [7:0]      flitCnt;
  logic [ID_W-1:0] destCnt;
  logic            groupEnd, flitAcc, lastFlit, lastDest;

  always_comb begin
    inReady  = (state == ST_COLLECT);
    outValid = (state == ST_SEND);
    busy     = groupOpen || (state == ST_SEND);

    st.take  = inValid && inReady;
    st.close = inLastNeuron || inLastGroup;
    groupEnd = st.take && (inLastGroup ||
               (st.close && (slotCount == SLOT_W'(SLOTS - 1))));

    flitAcc  = outValid && outReady;
    lastFlit = (flitCnt == 8'(slotCount));
    lastDest = (destCnt == peCount - 1'b1);

    st.hdrSel = (flitCnt == 8'd0);
    st.rdIdx  = flitCnt - 8'd1;
    st.dest   = 8'(firstPe + destCnt);
    st.clearSlots = (groupEnd && (peCount == '0)) ||
                    (flitAcc && lastFlit && lastDest);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_COLLECT;
      groupOpen <= 1'b0;
      flitCnt   <= '0;
      destCnt   <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (groupEnd) begin
            groupOpen <= 1'b0;
            flitCnt   <= '0;
            destCnt   <= '0;
            if (peCount != '0) state <= ST_SEND;
          end else if (st.take) begin
            groupOpen <= 1'b1;
          end
        end
        ST_SEND: begin
          if (flitAcc) begin
            if (lastFlit) begin
              flitCnt <= '0;
              destCnt <= destCnt + 1'b1;
              if (lastDest) state <= ST_COLLECT;
            end else begin
              flitCnt <= flitCnt + 8'd1;
            end
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/neuron_pe.sv
module neuron_pe
  import pe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int SLOTS  = 64,
  parameter int ID_W   = 8,
  localparam int SLOT_W = $clog2(SLOTS + 1),
  localparam int FLIT_W = 3 * ID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeMax,
  input  logic [ID_W-1:0]   srcPe,
  input  logic [ID_W-1:0]   firstPe,
  input  logic [ID_W-1:0]   peCount,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inWeight,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLastNeuron,
  input  logic              inLastGroup,
  output logic              outValid,
  input  logic              outReady,
  output logic [FLIT_W-1:0] outFlit,
  output logic              busy
);

  pe_strobe_t        strobes;
  logic [SLOT_W-1:0] slotCount;

  pe_control #(.SLOTS(SLOTS), .ID_W(ID_W)) u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inLastNeuron(inLastNeuron), .inLastGroup(inLastGroup),
    .slotCount(slotCount), .firstPe(firstPe), .peCount(peCount),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .busy(busy), .st(strobes)
  );

  pe_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SLOTS(SLOTS), .ID_W(ID_W)) u_datapath (
    .clk(clk), .rstN(rstN), .st(strobes), .modeMax(modeMax),
    .inWeight(inWeight), .inData(inData), .srcPe(srcPe),
    .slotCount(slotCount), .outFlit(outFlit)
  );

endmodule

// File: rtl/neuron_pe_checker.sv
module neuron_pe_checker #(
  parameter int SLOTS = 64,
  parameter int ID_W  = 8,
  localparam int FLIT_W = 3 * ID_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic              busy,
  input logic              hdrFlag,
  input logic [ID_W-1:0]   srcPe,
  input logic [FLIT_W-1:0] outFlit
);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outFlit)));

  assert_no_intake_while_send_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  assert_busy_covers_send_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  assert_header_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && hdrFlag) |-> (outFlit[2*ID_W-1:ID_W] == srcPe));

  assert_count_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && hdrFlag) |-> ((outFlit[ID_W-1:0] != '0) && (outFlit[ID_W-1:0] <= ID_W'(SLOTS))));

endmodule

bind neuron_pe neuron_pe_checker #(.SLOTS(SLOTS), .ID_W(ID_W)) u_checker (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .busy(busy), .hdrFlag(strobes.hdrSel),
  .srcPe(srcPe), .outFlit(outFlit)
);

// File: tb/neuron_pe_bench.sv
module neuron_pe_bench;

  localparam int SLOTS = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, modeMax, inValid, inReady, inLastNeuron, inLastGroup;
  logic        outValid, outReady, busy;
  logic [7:0]  srcPe, firstPe, peCount;
  logic [15:0] inWeight, inData;
  logic [23:0] outFlit;

  neuron_pe #(.SLOTS(SLOTS)) u_neuron_pe (
    .clk(clk), .rstN(rstN), .modeMax(modeMax), .srcPe(srcPe),
    .firstPe(firstPe), .peCount(peCount), .inValid(inValid),
    .inReady(inReady), .inWeight(inWeight), .inData(inData),
    .inLastNeuron(inLastNeuron), .inLastGroup(inLastGroup),
    .outValid(outValid), .outReady(outReady), .outFlit(outFlit), .busy(busy)
  );

  int          nChecks = 0;
  int          nFails  = 0;
  logic [15:0] expRes [64];
  int          nExp;
  longint      accM;
  bit          mFresh;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic newGroup();
    nExp = 0; accM = 0; mFresh = 1;
  endtask

  // drives one operand beat, called at a falling edge
  task automatic beat(input logic [15:0] w, input logic [15:0] d, input bit ln, input bit lg);
    longint a, b;
    inWeight = w; inData = d; inLastNeuron = ln; inLastGroup = lg; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    a = longint'($signed(w));
    b = longint'($signed(d));
    if (modeMax) begin
      if (mFresh || b > accM) accM = b;
    end else begin
      accM = (mFresh ? 0 : accM) + a * b;
    end
    mFresh = 0;
    if (ln || lg) begin
      if (accM > 32767)       expRes[nExp] = 16'h7fff;
      else if (accM < -32768) expRes[nExp] = 16'h8000;
      else                    expRes[nExp] = 16'(accM);
      nExp++;
      mFresh = 1;
    end
  endtask

  task automatic idleIn();
    inValid = 1'b0; inLastNeuron = 1'b0; inLastGroup = 1'b0;
  endtask

  task automatic drain(input int nDest, input bit stall);
    logic [23:0] exp, hold;
    for (int d = 0; d < nDest; d++) begin
      for (int f = 0; f <= nExp; f++) begin
        int guard = 0;
        while (!outValid && guard < 100) begin @(negedge clk); guard++; end
        if (d == 0 && f == 0) check(!inReady, "R8 intake closed while sending", inReady, 0);
        if (stall) begin
          hold = outFlit;
          @(negedge clk);
          check(outValid && outFlit == hold, "R7 stalled flit held", outFlit, hold);
        end
        if (f == 0) begin
          exp = {8'(firstPe + 8'(d)), srcPe, 8'(nExp)};
          check(outValid && outFlit == exp, "R6 header", outFlit, exp);
        end else begin
          exp = {8'h00, expRes[f-1]};
          check(outValid && outFlit == exp, "R5 payload", outFlit, exp);
        end
        outReady = 1'b1;
        @(negedge clk);
        outReady = 1'b0;
      end
    end
    check(!busy && inReady && !outValid, "R8 release after last flit",
          {busy, inReady, outValid}, 3'b010);
  endtask

  task automatic test_reset();
    check(!busy, "R1 busy low", busy, 0);
    check(!outValid, "R1 outValid low", outValid, 0);
    check(inReady, "R1 inReady high", inReady, 1);
  endtask

  task automatic test_sum();
    newGroup();
    modeMax = 0; srcPe = 8'd9; firstPe = 8'd5; peCount = 8'd2;
    beat(16'd2, 16'd3, 0, 0);
    check(busy, "R8 busy after first operand", busy, 1);
    beat(16'd4, -16'sd5, 0, 0);
    beat(-16'sd1, 16'd7, 1, 0);
    beat(16'd300, 16'd300, 0, 0);
    beat(-16'sd300, 16'd300, 0, 0);
    beat(16'd5, 16'd1, 1, 1);
    idleIn();
    check(expRes[0] == 16'hffeb && expRes[1] == 16'd5, "R2 model values", expRes[1], 5);
    drain(2, 0);
  endtask

  task automatic test_sat();
    newGroup();
    modeMax = 0; srcPe = 8'd1; firstPe = 8'd200; peCount = 8'd1;
    beat(16'h7fff, 16'h7fff, 0, 0);
    beat(16'h7fff, 16'h7fff, 0, 0);
    beat(16'h7fff, 16'h7fff, 1, 0);
    beat(16'h8000, 16'h7fff, 0, 0);
    beat(16'h8000, 16'h7fff, 0, 0);
    beat(16'h8000, 16'h7fff, 1, 1);
    idleIn();
    check(expRes[0] == 16'h7fff && expRes[1] == 16'h8000, "R3 clamp model", expRes[0], 32767);
    drain(1, 1);
  endtask

  task automatic test_max();
    newGroup();
    modeMax = 1; srcPe = 8'd3; firstPe = 8'd250; peCount = 8'd3;
    beat(16'h0000, -16'sd5, 0, 0);
    beat(16'h1234, -16'sd100, 0, 0);
    beat(16'hffff, -16'sd2, 1, 0);
    beat(16'h0000, 16'h8000, 1, 0);
    beat(16'h4000, 16'd7, 0, 0);
    beat(16'h0000, 16'h7fff, 0, 0);
    beat(16'h8000, 16'd0, 0, 1);   // R10: cluster end without neuron end
    idleIn();
    check(expRes[0] == 16'hfffe && expRes[2] == 16'h7fff, "R4 max model", expRes[0], -2);
    drain(3, 0);
  endtask

  task automatic test_noDest();
    newGroup();
    modeMax = 0; srcPe = 8'd4; firstPe = 8'd0; peCount = 8'd0;
    beat(16'd1, 16'd1, 1, 1);
    idleIn();
    check(!busy && inReady, "R6 zero destinations discard", busy, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!outValid, "R6 nothing sent with zero destinations", outValid, 0);
    end
  endtask

  task automatic test_full();
    newGroup();
    modeMax = 0; srcPe = 8'd7; firstPe = 8'd12; peCount = 8'd1;
    for (int i = 0; i < SLOTS; i++) beat(16'(i + 1), 16'd10, 1, 0);
    idleIn();
    check(!inReady && outValid, "R9 full buffer closes cluster", inReady, 0);
    drain(1, 0);
  endtask

  bit finished = 0;

  initial begin
    rstN = 0; modeMax = 0; srcPe = 0; firstPe = 0; peCount = 0;
    inWeight = 0; inData = 0; outReady = 0;
    idleIn();
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    test_reset();
    test_sum();
    test_sat();
    test_max();
    test_noDest();
    test_full();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule